// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital front end of a two-channel digital-to-analog converter. It receives 24-bit command frames on a write-only SPI-style port that has a chip select, a serial clock and a data line. It decodes each frame and keeps, for each channel, an input register and an output register. The output registers hold the codes that the converters present. The block also holds the reference-enable flag and a gain flag for each channel.

When an input value moves to an output depends on three things: a load-strobe pin, a load-enable bit for each channel, and software update commands. A channel whose enable bit is 0 follows the pin. While the pin is high, writes are staged, and a falling edge on the pin moves them to the output. A channel whose enable bit is 1 behaves as if the pin were held low. In that synchronous mode, a write reaches the output as soon as its frame completes. A software "update" command, or a combined "write then update all" command, does the job of the strobe without moving the pin.

All pins are sampled on the system clock `clk`. A serial-clock falling edge is detected when a high sample is followed by a low sample.

Top module: `dual_dac_regs`

## Requirements
- R1: A frame is 24 bits sent MSB first: 2 ignored bits, a 3-bit command, a 3-bit address, then 16 data bits. Each bit is captured on a serial-clock falling edge while chip select is low. The command takes effect on the 24th falling edge, and its results are visible one `clk` cycle after that edge is sampled.
- R2: Address 000 selects channel A, 001 selects channel B and 111 selects both. Any other address selects no channel.
- R3: Command 000 loads the data into the selected input register(s). It leaves an output unchanged if that channel's load-enable bit is 0 and the load pin is high.
- R4: Command 001 copies the input register to the output register for each selected channel only.
- R5: Command 010 loads the data into the selected input register(s) and then copies both input registers to both outputs.
- R6: When a channel's enable bit is 0, a falling edge on `load_n` copies that channel's input register to its output. When the enable bit is 1, the pin has no effect on that channel.
- R7: Command 110 sets the load-enable bits from data bit 0 (channel A) and data bit 1 (channel B).
- R8: A channel is in synchronous mode when its enable bit is 1 or `load_n` is low. In that mode, a write to the channel's input register also updates its output in the same frame.
- R9: Command 111 with data bit 0 set turns on `ref_on` and sets `gain_a` and `gain_b` to 1, meaning gain 2. With data bit 0 clear, the command has no effect.
- R10: After reset, all registers and outputs are 0: the load-enable bits, the reference flag and the gain flags (0 means gain 1).
- R11: If chip select rises before the 24th falling edge, the frame is discarded and no state changes. Falling edges after the 24th are ignored until chip select rises.
- R12: If a frame completes in the same `clk` cycle as a `load_n` falling edge, the written channel takes the new data (the pin is now low, so R8 applies). The other channel, if its enable bit is 0, takes its input register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock; bits are captured on its falling edge |
| mosi | input | 1 | Serial data in |
| load_n | input | 1 | Load strobe pin, active low |
| dac_a | output | 16 | Channel A output register |
| dac_b | output | 16 | Channel B output register |
| gain_a | output | 1 | Channel A gain flag (1 means gain 2) |
| gain_b | output | 1 | Channel B gain flag (1 means gain 2) |
| ref_on | output | 1 | Internal reference enabled |

## Verification
Two events can fall in the same `clk` cycle: the completion of a frame and a falling edge on the load pin. Each one can update an output. The bench drops `load_n` in the same cycle as the 24th serial-clock fall of a write to channel A, with both enable bits clear. It then expects channel A to show the freshly written code, because the pin is now low and synchronous mode applies. It expects channel B to show its previously staged input, because the pin edge moved it.

// File: rtl/dual_dac_regs.sv
module dual_dac_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              load_n,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              gain_a,
  output logic              gain_b,
  output logic              ref_on
);
  localparam int FRAME_W = DATA_W + 8;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int KEEP_W  = FRAME_W - 3;
  localparam logic [2:0] C_WR = 3'b000, C_UPD = 3'b001, C_WRUPD = 3'b010,
                         C_LDEN = 3'b110, C_REF = 3'b111;

  logic              sclk_q, ld_q;
  logic [KEEP_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        en_q;
  logic [DATA_W-1:0] in_q  [2];
  logic [DATA_W-1:0] out_q [2];

  wire sclk_fall = sclk_q & ~sclk;
  wire ld_fall   = ld_q & ~load_n;
  wire take      = ~cs_n & sclk_fall & (cnt_q < CNT_W'(FRAME_W));
  wire exec      = take & (cnt_q == CNT_W'(FRAME_W - 1));

  wire [2:0]        cmd  = shift_q[DATA_W+4:DATA_W+2];
  wire [2:0]        addr = shift_q[DATA_W+1:DATA_W-1];
  wire [DATA_W-1:0] data = {shift_q[DATA_W-2:0], mosi};

  logic [1:0] hit, wr, upd, sync;
  assign hit[0] = (addr == 3'b000) || (addr == 3'b111);
  assign hit[1] = (addr == 3'b001) || (addr == 3'b111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      ld_q    <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q <= sclk;
      ld_q   <= load_n;
      if (cs_n) cnt_q <= '0;
      else if (take) begin
        cnt_q   <= cnt_q + 1'b1;
        shift_q <= {shift_q[KEEP_W-2:0], mosi};
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign wr[c]   = exec & ((cmd == C_WR) | (cmd == C_WRUPD)) & hit[c];
    assign upd[c]  = (exec & (((cmd == C_UPD) & hit[c]) | (cmd == C_WRUPD)))
                   | (ld_fall & ~en_q[c]);
    assign sync[c] = en_q[c] | ~load_n;

    wire [DATA_W-1:0] in_next = wr[c] ? data : in_q[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q[c]  <= '0;
        out_q[c] <= '0;
      end else begin
        in_q[c] <= in_next;
        if (upd[c] | (wr[c] & sync[c])) out_q[c] <= in_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 2'b00;
      ref_on <= 1'b0;
      gain_a <= 1'b0;
      gain_b <= 1'b0;
    end else if (exec) begin
      if (cmd == C_LDEN) en_q <= data[1:0];
      if (cmd == C_REF && data[0]) begin
        ref_on <= 1'b1;
        gain_a <= 1'b1;
        gain_b <= 1'b1;
      end
    end
  end

  assign dac_a = out_q[0];
  assign dac_b = out_q[1];

  p_discard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt_q == '0));
  p_staged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == C_WR && hit[0] && !en_q[0] && load_n && !ld_fall) |=> $stable(dac_a));
  p_sync_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && wr[1] && sync[1]) |=> (dac_b == $past(data)));
  p_pin_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && en_q[0] && !exec) |=> $stable(dac_a));
  p_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == C_REF && data[0]) |=> (ref_on && gain_a && gain_b));
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec && !ld_fall) |=> ($stable(dac_a) && $stable(dac_b)));
endmodule

// File: tb/tb_dual_dac_regs.sv
module tb_dual_dac_regs;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, mosi = 0, load_n = 1;
  logic [15:0] dac_a, dac_b;
  logic gain_a, gain_b, ref_on;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dual_dac_regs dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .load_n(load_n), .dac_a(dac_a), .dac_b(dac_b), .gain_a(gain_a), .gain_b(gain_b),
    .ref_on(ref_on));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [2:0] cmd, logic [2:0] addr, logic [15:0] data,
                      int nbits = 24, bit drop_ld = 0);
    logic [23:0] f = {2'b11, cmd, addr, data};
    cs_n = 0; wait_clk(2);
    for (int i = 0; i < nbits; i++) begin
      mosi = f[23-i]; sclk = 1; wait_clk(2);
      sclk = 0;
      if (drop_ld && i == nbits - 1) load_n = 0;
      wait_clk(2);
    end
    cs_n = 1; wait_clk(3);
  endtask

  task automatic pulse_load();
    load_n = 0; wait_clk(3); load_n = 1; wait_clk(3);
  endtask

  task automatic t_reset();
    check("R10 dac_a", dac_a, 0); check("R10 dac_b", dac_b, 0);
    check("R10 flags", {gain_a, gain_b, ref_on}, 0);
  endtask

  task automatic t_staged_and_sw_update();
    send(3'b000, 3'b000, 16'h1234);
    check("R3 A staged", dac_a, 0);
    send(3'b000, 3'b001, 16'h5678);
    check("R3 B staged", dac_b, 0);
    send(3'b001, 3'b111, 16'h0);
    check("R4 A updated", dac_a, 16'h1234); check("R4 B updated", dac_b, 16'h5678);
  endtask

  task automatic t_addr_select();
    send(3'b000, 3'b111, 16'hAAAA);
    send(3'b000, 3'b011, 16'h9999);
    send(3'b001, 3'b000, 16'h0);
    check("R4 A only", dac_a, 16'hAAAA); check("R2 B untouched", dac_b, 16'h5678);
    send(3'b001, 3'b001, 16'h0);
    check("R2 both addr wrote B", dac_b, 16'hAAAA);
  endtask

  task automatic t_write_update_all();
    send(3'b000, 3'b000, 16'h1111);
    check("R3 A staged", dac_a, 16'hAAAA);
    send(3'b010, 3'b001, 16'h2222);
    check("R5 A", dac_a, 16'h1111); check("R5 B", dac_b, 16'h2222);
  endtask

  task automatic t_pin_strobe();
    send(3'b000, 3'b000, 16'h3333); send(3'b000, 3'b001, 16'h4444);
    check("R6 before pulse", dac_a, 16'h1111);
    pulse_load();
    check("R6 A", dac_a, 16'h3333); check("R6 B", dac_b, 16'h4444);
  endtask

  task automatic t_pin_held_low();
    load_n = 0; wait_clk(3);
    send(3'b000, 3'b001, 16'h5555);
    check("R8 pin low B", dac_b, 16'h5555);
    load_n = 1; wait_clk(3);
  endtask

  task automatic t_truncated();
    send(3'b000, 3'b000, 16'h7777);
    send(3'b001, 3'b000, 16'h0, 20);
    check("R11 short frame", dac_a, 16'h3333);
    send(3'b001, 3'b000, 16'h0);
    check("R1 full frame", dac_a, 16'h7777);
  endtask

  task automatic t_coincide();
    send(3'b000, 3'b001, 16'h8888);
    send(3'b000, 3'b000, 16'h6666, 24, 1);
    load_n = 1; wait_clk(3);
    check("R12 A new data", dac_a, 16'h6666); check("R12 B staged", dac_b, 16'h8888);
  endtask

  task automatic t_enable_bits();
    send(3'b110, 3'b000, 16'h0001);
    send(3'b000, 3'b000, 16'hABCD);
    check("R7 A sync", dac_a, 16'hABCD);
    send(3'b000, 3'b001, 16'hBEEF);
    check("R7 B staged", dac_b, 16'h8888);
    send(3'b000, 3'b000, 16'hC0DE);
    send(3'b000, 3'b000, 16'hC0DE);
    pulse_load();
    check("R6 B strobed", dac_b, 16'hBEEF); check("R8 A sync", dac_a, 16'hC0DE);
  endtask

  task automatic t_reference();
    send(3'b111, 3'b000, 16'h0000);
    check("R9 bit0 clear", {gain_a, gain_b, ref_on}, 0);
    send(3'b111, 3'b000, 16'h0001);
    check("R9 ref and gains", {gain_a, gain_b, ref_on}, 3'b111);
  endtask

  initial begin
    fork
      begin
        wait_clk(3); rst_n = 1; wait_clk(2);
        t_reset(); t_staged_and_sw_update(); t_addr_select(); t_write_update_all();
        t_pin_strobe(); t_pin_held_low(); t_truncated(); t_coincide();
        t_enable_bits(); t_reference();
      end
      begin
        wait_clk(100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule